// File: doc/BRIEF.md
# Single-Byte I2C Write Master

This block is a bus master that carries out one complete I2C write of a single byte to a device with a 7-bit address. The caller pulses a request together with an address and a data byte. The block then runs the whole transaction on its own:

- it waits for the bus to be free and generates a START;
- it shifts out the address byte with the write bit, then checks the acknowledge;
- it shifts out the data byte, then checks the acknowledge;
- it always closes with a STOP, even after a failure.

When the transaction ends, a one-cycle done pulse returns a two-bit result code.

Both bus lines are open-drain. The block only decides whether to pull each line low. It reads the resolved line levels back on two inputs. The SCL rate comes from an 8-bit bit-rate value `bit_rate` (BR): one SCL period lasts 16+2·BR system clocks. For 100 kHz the value is ((f_clk/100 kHz)−16)/2, masked to 8 bits. At 50 MHz this gives 242.

Each phase is guarded by a timeout counter of `TMO_CYCLES` cycles:

- the start phase times out if the bus does not go free;
- the address and data phases time out if a released SCL fails to rise.

A NACK counts as failure of the phase in which it occurs.

Top module: `i2c_byte_writer`

## Requirements
- R1: Out of reset and whenever no transaction is running, both lines are released (`scl_oe`=0, `sda_oe`=0), `busy` and `done` are 0, and `result` holds the last code (0 after reset).
- R2: A request accepted while idle starts a transaction. As soon as both lines read high, SDA is pulled low while SCL stays released, and this START lasts 8+BR cycles.
- R3: Every bit clock holds SCL low for 8+BR cycles and then released for 8+BR cycles, so one SCL period is 16+2·BR cycles.
- R4: SDA only changes while SCL is low, at low-phase cycle index (8+BR)/2. It stays constant while SCL is released.
- R5: The first byte is the 7-bit address shifted left by one with a 0 write bit appended, sent MSB first. A 0 bit pulls SDA low (`sda_oe`=1).
- R6: In the ninth clock of each byte SDA is released. `sda_in` is sampled in the last cycle of the high phase; low means ACK, high means NACK.
- R7: After an ACK on the address byte, the data byte follows MSB first in the same bit format.
- R8: `result` codes: 0 OK, 1 start error, 2 address error, 3 data error. A NACK on the address byte gives 2, and a NACK on the data byte gives 3.
- R9: If the bus does not read idle for `TMO_CYCLES` consecutive cycles after the request, the start phase fails with code 1.
- R10: If SCL does not read high within `TMO_CYCLES` cycles after being released during a bit, the current phase fails (2 for address, 3 for data).
- R11: Every transaction, successful or not, ends with a STOP:
  - SCL is pulled low, and SDA is pulled low at mid-phase;
  - SCL is then released for 8+BR cycles;
  - SDA is then released, and the bus stays free for 8+BR cycles;
  - `done` then pulses for one cycle with the result.
- R12: `busy` rises the cycle after the request is accepted and falls in the cycle `done` rises. Requests and changes on `dev_addr`/`wr_byte` while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_rate | input | 8 | SCL period value BR, period = 16+2·BR clocks, hold stable while busy |
| req | input | 1 | Start a write transaction (sampled while idle) |
| dev_addr | input | 7 | Target device address |
| wr_byte | input | 8 | Byte to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | Result code, valid from `done` until the next transaction |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| scl_in | input | 1 | Resolved SCL level |
| sda_in | input | 1 | Resolved SDA level |

## Verification
The hardest situations to reach from the ports are:
- a foreign device holding SCL low just as the master releases it in the middle of a byte;
- the bus staying occupied when a request arrives.

The bench drives these through its own wired-AND bus model. It asserts the SCL hold at the exact edge where the first bit of the chosen byte begins. It pulls SDA low from before the request to block the start. The same lockstep model pulls SDA low in each ninth clock for ACK, and leaves it high for NACK. A second request with a different address is injected during START, and the bench checks that the waveform is unchanged.

// File: rtl/i2c_byte_writer.sv
module i2c_byte_writer #(
  parameter int TMO_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bit_rate,
  input  logic       req,
  input  logic [6:0] dev_addr,
  input  logic [7:0] wr_byte,
  output logic       busy,
  output logic       done,
  output logic [1:0] result,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       scl_in,
  input  logic       sda_in
);

  localparam int TW = $clog2(TMO_CYCLES + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT_BUS, S_START, S_BIT_LO, S_BIT_HI, S_STOP_LO, S_STOP_HI, S_STOP_FREE
  } state_t;

  state_t      st;
  logic [8:0]  cnt;
  logic [TW-1:0] tmo;
  logic [7:0]  shreg, dbyte;
  logic [3:0]  bitn;
  logic        in_data;

  wire [8:0] span      = 9'd8 + {1'b0, bit_rate};
  wire [8:0] mid       = span >> 1;
  wire       last      = (cnt == span - 9'd1);
  wire       tmo_end   = (tmo == TW'(TMO_CYCLES - 1));
  wire [1:0] phase_err = in_data ? 2'd3 : 2'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      tmo     <= '0;
      shreg   <= '0;
      dbyte   <= '0;
      bitn    <= '0;
      in_data <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      result  <= 2'd0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req) begin
            busy    <= 1'b1;
            shreg   <= {dev_addr, 1'b0};
            dbyte   <= wr_byte;
            in_data <= 1'b0;
            tmo     <= '0;
            st      <= S_WAIT_BUS;
          end
        end
        S_WAIT_BUS: begin
          if (scl_in && sda_in) begin
            sda_oe <= 1'b1;
            cnt    <= '0;
            st     <= S_START;
          end else if (tmo_end) begin
            result <= 2'd1;
            scl_oe <= 1'b1;
            cnt    <= '0;
            st     <= S_STOP_LO;
          end else begin
            tmo <= tmo + 1'b1;
          end
        end
        S_START: begin
          if (last) begin
            scl_oe <= 1'b1;
            cnt    <= '0;
            bitn   <= '0;
            st     <= S_BIT_LO;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_BIT_LO: begin
          if (cnt == mid)
            sda_oe <= (bitn == 4'd8) ? 1'b0 : ~shreg[7];
          if (last) begin
            scl_oe <= 1'b0;
            cnt    <= '0;
            tmo    <= '0;
            st     <= S_BIT_HI;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_BIT_HI: begin
          if (!scl_in) begin
            if (tmo_end) begin
              result <= phase_err;
              scl_oe <= 1'b1;
              cnt    <= '0;
              st     <= S_STOP_LO;
            end else begin
              tmo <= tmo + 1'b1;
            end
          end else if (last) begin
            scl_oe <= 1'b1;
            cnt    <= '0;
            if (bitn == 4'd8) begin
              if (sda_in) begin
                result <= phase_err;
                st     <= S_STOP_LO;
              end else if (!in_data) begin
                in_data <= 1'b1;
                shreg   <= dbyte;
                bitn    <= '0;
                st      <= S_BIT_LO;
              end else begin
                result <= 2'd0;
                st     <= S_STOP_LO;
              end
            end else begin
              bitn  <= bitn + 1'b1;
              shreg <= {shreg[6:0], 1'b0};
              st    <= S_BIT_LO;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP_LO: begin
          if (cnt == mid) sda_oe <= 1'b1;
          if (last) begin
            scl_oe <= 1'b0;
            cnt    <= '0;
            st     <= S_STOP_HI;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP_HI: begin
          if (last) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= S_STOP_FREE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP_FREE: begin
          if (last) begin
            done <= 1'b1;
            busy <= 1'b0;
            st   <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (!scl_oe && !sda_oe && !busy));

  // R4
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT_HI && $past(st) == S_BIT_HI) |-> $stable(sda_oe));

  // R6
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT_HI && bitn == 4'd8) |-> !sda_oe);

  // R12
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R11
  done_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(!scl_oe) && $past(!sda_oe)));

endmodule

// File: tb/sim_i2c_byte_writer.sv
`timescale 1ns/1ps
module sim_i2c_byte_writer;
  localparam int TMO = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bit_rate = 8'd0;
  logic req = 1'b0;
  logic [6:0] dev_addr = '0;
  logic [7:0] wr_byte = '0;
  logic busy, done, scl_oe, sda_oe;
  logic [1:0] result;
  logic slv_sda = 1'b0, scl_hold = 1'b0;
  logic scl_in, sda_in;

  assign scl_in = ~(scl_oe | scl_hold);
  assign sda_in = ~(sda_oe | slv_sda);

  always #10 clk = ~clk;

  i2c_byte_writer #(.TMO_CYCLES(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_rate(bit_rate), .req(req),
    .dev_addr(dev_addr), .wr_byte(wr_byte), .busy(busy), .done(done),
    .result(result), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .scl_in(scl_in), .sda_in(sda_in));

  int vectors = 0, fails = 0;
  logic e_scl = 0, e_sda = 0, e_busy = 0, e_done = 0;
  int e_res = 0;
  int H = 8, HALF = 4;
  logic cur = 0;
  string ctx = "R1";

  always @(negedge clk) begin
    vectors++;
    if (scl_oe !== e_scl) begin fails++; $display("FAIL %s scl_oe actual %b expected %b at %0t", ctx, scl_oe, e_scl, $time); end
    if (sda_oe !== e_sda) begin fails++; $display("FAIL %s sda_oe actual %b expected %b at %0t", ctx, sda_oe, e_sda, $time); end
    if (busy !== e_busy) begin fails++; $display("FAIL R12 busy actual %b expected %b at %0t", busy, e_busy, $time); end
    if (done !== e_done) begin fails++; $display("FAIL R11 done actual %b expected %b at %0t", done, e_done, $time); end
    if (!e_busy && result !== 2'(e_res)) begin
      fails++; $display("FAIL R8 result actual %0d expected %0d at %0t", result, e_res, $time);
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic tick(logic s, logic d);
    @(posedge clk); e_scl = s; e_sda = d;
  endtask

  task automatic hold(int n, logic s, logic d);
    repeat (n) tick(s, d);
  endtask

  task automatic stop_seq(int code);
    ctx = "R11";
    tick(1, cur); slv_sda <= 1'b0; scl_hold <= 1'b0;
    hold(HALF, 1, cur);
    hold(H - HALF - 1, 1, 1);
    hold(H, 0, 1);
    hold(H, 0, 0);
    @(posedge clk); e_done = 1; e_busy = 0; e_res = code; ctx = "R8";
    @(posedge clk); e_done = 0; ctx = "R1";
    cur = 0;
  endtask

  task automatic bit_cycle(logic drive_low, logic is_ack, logic ackv, logic stuck, output logic aborted);
    aborted = 0;
    tick(1, cur);
    slv_sda <= is_ack ? ackv : 1'b0;
    if (stuck) begin scl_hold <= 1'b1; ctx = "R10"; end
    if (is_ack) ctx = "R6";
    hold(HALF, 1, cur);
    cur = is_ack ? 1'b0 : drive_low;
    hold(H - HALF - 1, 1, cur);
    if (stuck) begin hold(TMO, 0, cur); aborted = 1; end
    else hold(H, 0, cur);
  endtask

  task automatic send_byte(logic [7:0] b, logic ackv, logic stuck_first, output logic fail);
    logic ab;
    fail = 0;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(~b[i], 1'b0, 1'b0, stuck_first && i == 7, ab);
      if (ab) begin fail = 1; return; end
    end
    bit_cycle(1'b0, 1'b1, ackv, 1'b0, ab);
    fail = !ackv;
  endtask

  // stuck: 0 none, 1 address phase, 2 data phase
  task automatic run(int br, logic [6:0] a, logic [7:0] d, logic bus_busy,
                     logic ack_a, logic ack_d, int stuck, logic poke);
    logic f;
    H = 8 + br; HALF = H / 2;
    @(posedge clk);
    bit_rate <= 8'(br); req <= 1'b1; dev_addr <= a; wr_byte <= d;
    if (bus_busy) slv_sda <= 1'b1;
    ctx = "R2";
    @(posedge clk);
    req <= 1'b0; dev_addr <= ~a; wr_byte <= ~d;
    e_busy = 1; e_scl = 0; e_sda = 0;
    if (bus_busy) begin
      ctx = "R9";
      hold(TMO - 1, 0, 0);
      cur = 0;
      stop_seq(1);
      return;
    end
    tick(0, 1);
    if (poke) begin
      ctx = "R12 R2";
      req <= 1'b1; dev_addr <= 7'h12; wr_byte <= 8'h34;
      tick(0, 1);
      req <= 1'b0;
      hold(H - 2, 0, 1);
    end else begin
      hold(H - 1, 0, 1);
    end
    cur = 1;
    ctx = "R5 R3 R4";
    send_byte({a, 1'b0}, ack_a, stuck == 1, f);
    if (f) begin stop_seq(2); return; end
    ctx = "R7 R3 R4";
    send_byte(d, ack_d, stuck == 2, f);
    if (f) begin stop_seq(3); return; end
    stop_seq(0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    rst_n <= 1'b1;
    repeat (3) @(posedge clk);
    run(0,   7'h3F, 8'hA5, 0, 1, 1, 0, 0);   // R5 R7 R8 success
    run(3,   7'h55, 8'h00, 0, 0, 1, 0, 0);   // R6 R8 address NACK
    run(1,   7'h2A, 8'h5A, 0, 1, 0, 0, 0);   // R8 data NACK
    run(2,   7'h10, 8'h11, 1, 1, 1, 0, 0);   // R9 bus occupied
    run(0,   7'h01, 8'hF0, 0, 1, 1, 1, 0);   // R10 SCL held in address
    run(4,   7'h66, 8'h80, 0, 1, 1, 2, 0);   // R10 SCL held in data
    run(5,   7'h7F, 8'hFF, 0, 1, 1, 0, 1);   // R12 request ignored while busy
    run(242, 7'h00, 8'h81, 0, 1, 1, 0, 0);   // R3 100 kHz setting
    repeat (3) @(posedge clk);
    summary();
    $finish;
  end
endmodule